// File: doc/BRIEF.md
# Two-Wire Escape and Activation Sequencer

This block runs on the host side of a two-wire debug link. It takes a target out of reset and puts it into the online two-wire scan format. It is started with a one-cycle pulse, and that pulse must be given after every TAP reset, because a reset leaves the target offline and not activated.

Once started, the block drives the clock line (TCK) and the bidirectional data line (TMSC) through a fixed list of steps:

1. A baseline step with both lines low.
2. A reset escape.
3. A selection escape.
4. A 12-bit activation command.

An escape is not clocked data. The target recognises it by counting TMSC toggles made while TCK is held high. The activation command uses ordinary clock pulses: each bit is set up while TCK is low and taken by the target on the rising edge.

Every step holds its line levels for a programmable number of system clocks, with a minimum of one. When the last step has run, the block pulses done.

Top module: `cjt_act_seq`

## Requirements
- R1: After reset, TCK and TMSC are low, busy is low and done is low.
- R2: An accepted start first drives one baseline step with TCK=0 and TMSC=0, and busy rises in that cycle.
- R3: Reset escape. One step with TCK=1 and TMSC=0, then 8 steps with TCK=1 in which TMSC alternates 1,0,1,0,1,0,1,0, then one step with TCK=0 and TMSC=0.
- R4: Selection escape. One step with TCK=1 and TMSC=0, then 6 steps with TCK=1 in which TMSC alternates 1,0,1,0,1,0, then one step with TCK=0 and TMSC=0.
- R5: The 12 activation bits go out lowest bit first. Each bit is a low-clock step (TCK=0, TMSC=bit) followed by a high-clock step (TCK=1, TMSC=bit). The bits are, in order:
  - option code 0,0,1,1;
  - extension code 0,0,0,1;
  - check packet 0,0,0,0.
- R6: Every step lasts max(hold_i,1) system clocks. hold_i is sampled in the cycle the step begins.
- R7: Done is high for exactly one clock, in the clock after the final high-clock step ends. Busy is low in that same clock. While idle, the line levels of the final step are kept.
- R8: A start pulse is ignored while busy is high. Busy is high up to and including the last cycle of the final step.
- R9: TMSC never changes on the same clock that TCK rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a sequence when the block is idle |
| hold_i | input | HOLD_W | Step length in system clocks; 0 is taken as 1 |
| tck_o | output | 1 | Level driven onto the link clock |
| tmsc_o | output | 1 | Level driven onto the link data line |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-clock pulse when the sequence completes |

## Verification
Two things can land on the same clock: the completion pulse of one run, and a start request for the next. A start held high across the end of a run is therefore seen both in the done cycle and in the idle cycle after it. The judgement is that it must be refused in the final busy cycle and accepted only once busy has dropped. Start pulses are also placed in the middle of escapes and activation bits, and a behavioural step queue, compared on every clock, shows that the line pattern runs on unchanged.

// File: rtl/cjt_act_pkg.sv
package cjt_act_pkg;

   typedef struct packed {
      logic clk;
      logic dat;
   } wire_lvl_t;

   // Line levels for one step of the sequence.
   // Step layout: baseline, reset escape, selection escape, activation bits.
   function automatic wire_lvl_t step_lvl(input int idx, input int rst_e,
                                          input int sel_e, input logic [31:0] word);
      int        rs;
      int        ss;
      int        as;
      int        k;
      wire_lvl_t v;
      rs = 1;
      ss = rs + rst_e + 2;
      as = ss + sel_e + 2;
      v  = '0;
      if (idx == 0) begin
         v = '0;
      end else if (idx < ss) begin
         k = idx - rs;
         v.clk = (k <= rst_e);
         v.dat = (k >= 1) && (k <= rst_e) && (k % 2 == 1);
      end else if (idx < as) begin
         k = idx - ss;
         v.clk = (k <= sel_e);
         v.dat = (k >= 1) && (k <= sel_e) && (k % 2 == 1);
      end else begin
         k = idx - as;
         v.clk = (k % 2 == 1);
         v.dat = word[(k / 2) % 32];
      end
      return v;
   endfunction

endpackage

// File: rtl/cjt_hold_timer.sv
module cjt_hold_timer #(
   parameter int HOLD_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              expire_o
);
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= (hold_i == '0) ? '0 : hold_i - HOLD_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - HOLD_W'(1);
      end
   end

   assign expire_o = (cnt_q == '0);

   // A step of one clock ends right after it is loaded
   p_short_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && hold_i <= HOLD_W'(1)) |=> expire_o);

   // A running count only moves down by one per clock
   p_count_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !expire_o) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));

endmodule

// File: rtl/cjt_step_rom.sv
module cjt_step_rom
   import cjt_act_pkg::*;
#(
   parameter int          RST_EDGES = 8,
   parameter int          SEL_EDGES = 6,
   parameter logic [31:0] ACT_WORD  = 32'h0000_08C,
   parameter int          NUM_STEPS = 43,
   parameter int          STEP_W    = 6
) (
   input  logic [STEP_W-1:0] idx_i,
   output wire_lvl_t         lvl_o
);
   wire_lvl_t tbl [NUM_STEPS];

   for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_step
      assign tbl[gi] = step_lvl(gi, RST_EDGES, SEL_EDGES, ACT_WORD);
   end

   always_comb begin
      lvl_o = '0;
      if (32'(idx_i) < NUM_STEPS) lvl_o = tbl[idx_i];
   end

endmodule

// File: rtl/cjt_act_seq.sv
module cjt_act_seq
   import cjt_act_pkg::*;
#(
   parameter int                 HOLD_W    = 8,
   parameter int                 RST_EDGES = 8,
   parameter int                 SEL_EDGES = 6,
   parameter int                 FIELD_W   = 4,
   parameter logic [FIELD_W-1:0] OPT_CODE  = 4'b1100,
   parameter logic [FIELD_W-1:0] EXT_CODE  = 4'b1000,
   parameter logic [FIELD_W-1:0] CHK_CODE  = 4'b0000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              tck_o,
   output logic              tmsc_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int          ACT_BITS  = 3 * FIELD_W;
   localparam int          NUM_STEPS = 1 + (RST_EDGES + 2) + (SEL_EDGES + 2) + 2 * ACT_BITS;
   localparam int          STEP_W    = $clog2(NUM_STEPS + 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
   localparam logic [31:0] ACT_WORD  = 32'({CHK_CODE, EXT_CODE, OPT_CODE});

   if (RST_EDGES < 2 || RST_EDGES % 2 != 0) begin : g_bad_rst
      $error("RST_EDGES must be even and at least 2");
   end
   if (SEL_EDGES < 2 || SEL_EDGES % 2 != 0) begin : g_bad_sel
      $error("SEL_EDGES must be even and at least 2");
   end
   if (ACT_BITS > 32) begin : g_bad_field
      $error("activation word limited to 32 bits");
   end
   if (HOLD_W < 1) begin : g_bad_hold
      $error("HOLD_W must be at least 1");
   end

   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] rom_idx;
   wire_lvl_t         lvl;
   logic              expire;
   logic              accept;
   logic              advance;
   logic              timer_load;

   assign accept     = !busy_o && start_i;
   assign advance    = busy_o && expire;
   assign timer_load = accept || (advance && step_q != LAST_STEP);
   assign rom_idx    = busy_o ? step_q + STEP_W'(1) : '0;

   cjt_step_rom #(
      .RST_EDGES(RST_EDGES),
      .SEL_EDGES(SEL_EDGES),
      .ACT_WORD (ACT_WORD),
      .NUM_STEPS(NUM_STEPS),
      .STEP_W   (STEP_W)
   ) rom_i (
      .idx_i(rom_idx),
      .lvl_o(lvl)
   );

   cjt_hold_timer #(
      .HOLD_W(HOLD_W)
   ) timer_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (timer_load),
      .hold_i  (hold_i),
      .expire_o(expire)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         step_q <= '0;
         tck_o  <= 1'b0;
         tmsc_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            busy_o <= 1'b1;
            step_q <= '0;
            tck_o  <= lvl.clk;
            tmsc_o <= lvl.dat;
         end else if (advance) begin
            if (step_q == LAST_STEP) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               step_q <= step_q + STEP_W'(1);
               tck_o  <= lvl.clk;
               tmsc_o <= lvl.dat;
            end
         end
      end
   end

   p_tmsc_steady_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tck_o) |-> $stable(tmsc_o));

   p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (step_q >= $past(step_q)));

   p_idle_levels_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> ($stable(tck_o) && $stable(tmsc_o)));

   p_start_baseline_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i) |=> (busy_o && !tck_o && !tmsc_o));

endmodule

// File: tb/cjt_act_seq_tb_top.sv
`timescale 1ns/1ps
module cjt_act_seq_tb_top;
   localparam int HW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [HW-1:0] hold;
   logic          tck, tmsc, busy, done;

   always #2.5 clk = ~clk;

   cjt_act_seq #(.HOLD_W(HW)) dut_i (
      .clk_i (clk),
      .rst_ni(rst_n),
      .start_i(start),
      .hold_i(hold),
      .tck_o (tck),
      .tmsc_o(tmsc),
      .busy_o(busy),
      .done_o(done)
   );

   typedef struct {
      bit    c;
      bit    d;
      string tag;
   } ent_t;

   ent_t  q[$];
   bit    m_tck, m_tmsc, m_busy, m_done;
   string m_tag = "R1";
   int    n_checks = 0;
   int    n_fail = 0;
   int    cycles = 0;
   bit    checking = 1'b0;

   task automatic push_step(bit c, bit d, string tag, int h);
      ent_t e;
      e.c = c;
      e.d = d;
      e.tag = tag;
      for (int i = 0; i < h; i++) q.push_back(e);
   endtask

   task automatic push_run(int h_in);
      int h;
      bit act[12];
      h = (h_in == 0) ? 1 : h_in;
      act = '{0,0,1,1, 0,0,0,1, 0,0,0,0};
      push_step(0, 0, "R2", h);
      push_step(1, 0, "R3", h);
      for (int i = 0; i < 8; i++) push_step(1, (i % 2 == 0), "R3", h);
      push_step(0, 0, "R3", h);
      push_step(1, 0, "R4", h);
      for (int i = 0; i < 6; i++) push_step(1, (i % 2 == 0), "R4", h);
      push_step(0, 0, "R4", h);
      for (int i = 0; i < 12; i++) begin
         push_step(0, act[i], "R5", h);
         push_step(1, act[i], "R5", h);
      end
   endtask

   // Behavioural reference model, one update per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_tck = 0; m_tmsc = 0; m_busy = 0; m_done = 0; m_tag = "R1";
      end else begin
         m_done = 0;
         if (!m_busy && start) push_run(int'(hold));
         if (q.size() > 0) begin
            ent_t e;
            e = q.pop_front();
            m_tck = e.c; m_tmsc = e.d; m_tag = e.tag; m_busy = 1;
         end else if (m_busy) begin
            m_busy = 0;
            m_done = 1;
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cycles, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (checking) begin
         chk(m_tag, "tck (R6 timing)", int'(tck), int'(m_tck));
         chk(m_tag, "tmsc (R6 timing)", int'(tmsc), int'(m_tmsc));
         chk("R8", "busy", int'(busy), int'(m_busy));
         chk("R7", "done", int'(done), int'(m_done));
      end
      if (cycles > 100000) begin
         n_fail++;
         $display("FAIL watchdog expired: actual %0d expected <= 100000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic wait_neg(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One run with the given hold; optional stray starts at chosen offsets (R8)
   task automatic run(int h, bit strays);
      int len;
      len = 43 * ((h == 0) ? 1 : h);
      @(negedge clk);
      hold  = HW'(h);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (strays) begin
         for (int k = 1; k < 6; k++) begin
            wait_neg(len / 6 - 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
         end
      end
      wait (!busy);
      wait_neg(3);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      hold  = HW'(1);
      wait_neg(3);
      // R1: reset state
      chk("R1", "tck", int'(tck), 0);
      chk("R1", "tmsc", int'(tmsc), 0);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      rst_n = 1'b1;
      checking = 1'b1;
      run(1, 1'b0);   // R2..R5 at minimum hold
      run(3, 1'b1);   // R6 longer hold, R8 stray starts
      run(0, 1'b0);   // R6 zero hold acts as one
      run(2, 1'b1);
      // R7/R8: start held high across the end of a run
      @(negedge clk);
      hold  = HW'(1);
      start = 1'b1;
      wait (done);
      wait_neg(3);
      start = 1'b0;
      wait (!busy);
      wait_neg(4);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule